// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block is the command front end of an SD host controller. Software first loads a 32-bit command argument and then writes a 16-bit command word. When the word is legal and no command is in flight, the block accepts it and raises a busy status. It then shifts a 48-bit command frame out on a serial line, one bit for each card-clock enable. It listens for the card's reply and left-shifts the reply's payload bits into a 128-bit response register.

When a command ends, the block produces single-cycle events for the interrupt unit: response end, response timeout, command-index error, and illegal access. An illegal access is a write while the block is busy, or a command word whose settings contradict each other. CRC7 generation and checking are handled elsewhere, so the seven CRC positions of the outgoing frame are driven low. The data path and the line drivers are outside this block.

Top module: `sd_cmd_frontend`

## Requirements
- R1: An accepted command is sent MSB first, one bit per card-clock enable. The frame is a start 0, a 1, the index (word bits 5:0), the last written argument (bit 31 first), seven zero CRC slots and an end 1. Bit k appears on `cmd_out` after the k-th enabled clock edge following the accepting edge, and `cmd_oe` is high only during the frame.
- R2: A legal write while idle raises `cmd_busy` on the accepting edge. `cmd_busy` stays high until the command completes, times out or ends its busy wait.
- R3: A command write while `cmd_busy` is high pulses `ev_illegal` on that edge. The command in flight is unaffected and completes on its original schedule.
- R4: Command word bit 11 (data present) together with response type 3 (bits 10:8) or with index 12 is rejected with `ev_illegal`, and nothing is issued. Response types 0, 1 and 2 are reserved and are rejected the same way.
- R5: With response type 3 (none), `cmd_busy` clears and `ev_rsp_end` pulses on the enabled edge that completes the end bit, which is the 48th enabled edge after acceptance.
- R6: For 48-bit responses (types 4, 5 and 7), the 32 payload bits after the start, transmission and six index bits are shifted into the response register from the LSB. Earlier contents move up by 32 bits.
- R7: For a 136-bit response (type 6), the register is cleared when the start bit arrives. It then receives the 120 bits that follow the first eight, so bits 119:0 hold the payload and bits 127:120 read zero.
- R8: `ev_rsp_end` pulses on the edge that samples the last response bit. For type 5 it is held back until `card_busy` is sampled low on an enabled edge.
- R9: If no response start bit (a valid 0) arrives within 64 card-clock enables after the frame ends, `ev_timeout` pulses on the 64th enable and `cmd_busy` clears.
- R10: For types 4 and 5, a received index that differs from the issued one pulses `ev_idx_err` together with `ev_rsp_end`. Types 6 and 7 never raise it.
- R11: All events are single-cycle pulses, and `ev_rsp_end` and `ev_timeout` never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_ce | input | 1 | Card-clock enable, one pulse per card bit time |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command word write strobe, starts an issue |
| cmd_wdata | input | 16 | Command word |
| cmd_out | output | 1 | Serial command bit |
| cmd_oe | output | 1 | High while the frame is driven |
| rsp_vld | input | 1 | Response bit valid (with card_ce) |
| rsp_bit | input | 1 | Response bit |
| card_busy | input | 1 | Card busy indication for type 5 |
| cmd_busy | output | 1 | Command in flight |
| rsp_reg | output | 128 | Response register |
| ev_rsp_end | output | 1 | Response end event |
| ev_idx_err | output | 1 | Command-index mismatch event |
| ev_timeout | output | 1 | Response timeout event |
| ev_illegal | output | 1 | Illegal access event |

## Verification
Every result has a fixed edge. `ev_illegal` follows the write by one edge. Frame bit k is present after the k-th edge from acceptance, and a no-response command ends on the 48th. Response results, including the register value, are due on the edge that samples the final bit. A timeout is due on the 64th enable after the frame ends, and a type-5 completion on the first enabled edge that sees `card_busy` low. The bench drives and samples on falling edges and counts the edges to each result. It checks one edge early that nothing has happened yet, and then checks the exact edge.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    RT_RSV0  = 3'd0,
    RT_RSV1  = 3'd1,
    RT_RSV2  = 3'd2,
    RT_NONE  = 3'd3,
    RT_R48   = 3'd4,
    RT_R48B  = 3'd5,
    RT_R136  = 3'd6,
    RT_R48NC = 3'd7
  } rsp_type_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RSP  = 2'd2,
    ST_BUSY = 2'd3
  } ctl_state_e;

  localparam int unsigned IDX_W      = 6;
  localparam int unsigned CMD_W      = 16;
  localparam logic [IDX_W-1:0] STOP_IDX = 6'd12;

endpackage

// File: rtl/sd_cmd_legal.sv
module sd_cmd_legal
  import sd_cmd_pkg::*;
(
  input  logic             we,
  input  logic             busy,
  input  logic [IDX_W-1:0] idx,
  input  rsp_type_e        rtype,
  input  logic             data,
  output logic             accept,
  output logic             reject
);

  logic rsv_type;
  logic bad_data;
  logic field_bad;

  always_comb begin
    rsv_type  = (rtype == RT_RSV0) || (rtype == RT_RSV1) || (rtype == RT_RSV2);
    bad_data  = data && ((rtype == RT_NONE) || (idx == STOP_IDX));
    field_bad = rsv_type || bad_data;
    accept    = we && !busy && !field_bad;
    reject    = we && (busy || field_bad);
  end

endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load,
  input  logic [IDX_W-1:0] idx,
  input  logic [ARG_W-1:0] arg,
  output logic             out_bit,
  output logic             out_en,
  output logic             done
);

  localparam int unsigned FR_W  = ARG_W + 16;
  localparam int unsigned CNT_W = $clog2(FR_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FR_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [FR_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = {1'b0, 1'b1, idx, arg, 7'd0, 1'b1};
      cnt_d = CNT_FULL;
    end else if (ce && (cnt_q != '0)) begin
      sh_d  = {sh_q[FR_W-2:0], 1'b0};
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign out_bit = sh_q[FR_W-1];
  assign out_en  = (cnt_q != '0);
  assign done    = ce && (cnt_q == CNT_ONE);

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W = 32,
  parameter int unsigned RSP_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             listen,
  input  logic             ce,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  rsp_type_e        rtype,
  input  logic [IDX_W-1:0] exp_idx,
  output logic             start,
  output logic             active,
  output logic             done,
  output logic             idx_bad,
  output logic [RSP_W-1:0] rsp
);

  localparam int unsigned LEN_S = ARG_W + 16;
  localparam int unsigned LEN_L = RSP_W + 8;
  localparam int unsigned POS_W = $clog2(LEN_L + 1);
  localparam logic [POS_W-1:0] LAST_S  = POS_W'(LEN_S - 1);
  localparam logic [POS_W-1:0] LAST_L  = POS_W'(LEN_L - 1);
  localparam logic [POS_W-1:0] PAY_LO  = POS_W'(8);
  localparam logic [POS_W-1:0] PHI_S   = POS_W'(ARG_W + 7);
  localparam logic [POS_W-1:0] PHI_L   = POS_W'(RSP_W - 1);
  localparam logic [POS_W-1:0] IDX_LO  = POS_W'(2);
  localparam logic [POS_W-1:0] IDX_HI  = POS_W'(7);
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

  logic             act_q, act_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [RSP_W-1:0] rsp_q, rsp_d;
  logic             take, is_long, chk_idx;
  logic [POS_W-1:0] last_pos, pay_hi;

  always_comb begin
    take     = ce && bit_vld;
    is_long  = (rtype == RT_R136);
    chk_idx  = (rtype == RT_R48) || (rtype == RT_R48B);
    last_pos = is_long ? LAST_L : LAST_S;
    pay_hi   = is_long ? PHI_L : PHI_S;
    start    = listen && !act_q && take && !bit_in;
    done     = act_q && take && (pos_q == last_pos);
    idx_bad  = done && chk_idx && (idx_q != exp_idx);
  end

  always_comb begin
    act_d = act_q;
    pos_d = pos_q;
    idx_d = idx_q;
    rsp_d = rsp_q;
    if (start) begin
      act_d = 1'b1;
      pos_d = POS_ONE;
      if (is_long) rsp_d = '0;
    end else if (act_q && take) begin
      if ((pos_q >= IDX_LO) && (pos_q <= IDX_HI))
        idx_d = {idx_q[IDX_W-2:0], bit_in};
      if ((pos_q >= PAY_LO) && (pos_q <= pay_hi))
        rsp_d = {rsp_q[RSP_W-2:0], bit_in};
      pos_d = pos_q + POS_ONE;
      if (done) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pos_q <= '0;
      idx_q <= '0;
      rsp_q <= '0;
    end else begin
      act_q <= act_d;
      pos_q <= pos_d;
      idx_q <= idx_d;
      rsp_q <= rsp_d;
    end
  end

  assign active = act_q;
  assign rsp    = rsp_q;

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce,
  input  logic      accept,
  input  logic      reject,
  input  rsp_type_e acc_rtype,
  input  logic      tx_done,
  input  logic      rx_start,
  input  logic      rx_active,
  input  logic      rx_done,
  input  logic      rx_idx_bad,
  input  logic      card_busy,
  output logic      busy,
  output logic      listen,
  output rsp_type_e rtype,
  output logic      ev_rsp_end,
  output logic      ev_timeout,
  output logic      ev_illegal,
  output logic      ev_idx_err
);

  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);

  ctl_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  rsp_type_e        rt_q, rt_d;
  logic             bad_q, bad_d;
  logic             end_q, end_d;
  logic             to_q, to_d;
  logic             ill_q, ill_d;
  logic             ie_q, ie_d;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    rt_d  = rt_q;
    bad_d = bad_q;
    end_d = 1'b0;
    to_d  = 1'b0;
    ill_d = reject;
    ie_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d  = ST_TX;
          rt_d  = acc_rtype;
          bad_d = 1'b0;
        end
      end
      ST_TX: begin
        if (tx_done) begin
          tmr_d = '0;
          if (rt_q == RT_NONE) begin
            st_d  = ST_IDLE;
            end_d = 1'b1;
          end else begin
            st_d = ST_RSP;
          end
        end
      end
      ST_RSP: begin
        if (rx_done) begin
          if (rt_q == RT_R48B) begin
            st_d  = ST_BUSY;
            bad_d = rx_idx_bad;
          end else begin
            st_d  = ST_IDLE;
            end_d = 1'b1;
            ie_d  = rx_idx_bad;
          end
        end else if (ce && !rx_active && !rx_start) begin
          if (tmr_q == TMR_LAST) begin
            st_d = ST_IDLE;
            to_d = 1'b1;
          end else begin
            tmr_d = tmr_q + TMR_ONE;
          end
        end
      end
      ST_BUSY: begin
        if (ce && !card_busy) begin
          st_d  = ST_IDLE;
          end_d = 1'b1;
          ie_d  = bad_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      rt_q  <= RT_NONE;
      bad_q <= 1'b0;
      end_q <= 1'b0;
      to_q  <= 1'b0;
      ill_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      rt_q  <= rt_d;
      bad_q <= bad_d;
      end_q <= end_d;
      to_q  <= to_d;
      ill_q <= ill_d;
      ie_q  <= ie_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign listen     = (st_q == ST_RSP);
  assign rtype      = rt_q;
  assign ev_rsp_end = end_q;
  assign ev_timeout = to_q;
  assign ev_illegal = ill_q;
  assign ev_idx_err = ie_q;

endmodule

// File: rtl/sd_cmd_frontend.sv
module sd_cmd_frontend
  import sd_cmd_pkg::*;
#(
  parameter int unsigned ARG_W       = 32,
  parameter int unsigned RSP_W       = 128,
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_ce,
  input  logic             arg_we,
  input  logic [ARG_W-1:0] arg_wdata,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic             cmd_out,
  output logic             cmd_oe,
  input  logic             rsp_vld,
  input  logic             rsp_bit,
  input  logic             card_busy,
  output logic             cmd_busy,
  output logic [RSP_W-1:0] rsp_reg,
  output logic             ev_rsp_end,
  output logic             ev_idx_err,
  output logic             ev_timeout,
  output logic             ev_illegal
);

  logic             rs0_q, rs1_q, core_rst_n;
  logic [ARG_W-1:0] arg_q, arg_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             accept, reject;
  logic             tx_done;
  logic             rx_start, rx_active, rx_done, rx_idx_bad;
  logic             listen;
  rsp_type_e        cur_rtype;
  rsp_type_e        wr_rtype;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_data;
  logic             unused_fields;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign core_rst_n = rs1_q;

  assign wr_idx        = cmd_wdata[5:0];
  assign wr_rtype      = rsp_type_e'(cmd_wdata[10:8]);
  assign wr_data       = cmd_wdata[11];
  assign unused_fields = ^{cmd_wdata[15:12], cmd_wdata[7:6]};

  always_comb begin
    arg_d = arg_we ? arg_wdata : arg_q;
    idx_d = accept ? wr_idx : idx_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      arg_q <= '0;
      idx_q <= '0;
    end else begin
      arg_q <= arg_d;
      idx_q <= idx_d;
    end
  end

  sd_cmd_legal u_legal (
    .we     (cmd_we),
    .busy   (cmd_busy),
    .idx    (wr_idx),
    .rtype  (wr_rtype),
    .data   (wr_data),
    .accept (accept),
    .reject (reject)
  );

  sd_cmd_tx #(.ARG_W(ARG_W)) u_tx (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .ce      (card_ce),
    .load    (accept),
    .idx     (wr_idx),
    .arg     (arg_q),
    .out_bit (cmd_out),
    .out_en  (cmd_oe),
    .done    (tx_done)
  );

  sd_cmd_rx #(.ARG_W(ARG_W), .RSP_W(RSP_W)) u_rx (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .listen  (listen),
    .ce      (card_ce),
    .bit_vld (rsp_vld),
    .bit_in  (rsp_bit),
    .rtype   (cur_rtype),
    .exp_idx (idx_q),
    .start   (rx_start),
    .active  (rx_active),
    .done    (rx_done),
    .idx_bad (rx_idx_bad),
    .rsp     (rsp_reg)
  );

  sd_cmd_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .ce         (card_ce),
    .accept     (accept),
    .reject     (reject),
    .acc_rtype  (wr_rtype),
    .tx_done    (tx_done),
    .rx_start   (rx_start),
    .rx_active  (rx_active),
    .rx_done    (rx_done),
    .rx_idx_bad (rx_idx_bad),
    .card_busy  (card_busy),
    .busy       (cmd_busy),
    .listen     (listen),
    .rtype      (cur_rtype),
    .ev_rsp_end (ev_rsp_end),
    .ev_timeout (ev_timeout),
    .ev_illegal (ev_illegal),
    .ev_idx_err (ev_idx_err)
  );

endmodule

// File: rtl/sd_cmd_frontend_chk.sv
module sd_cmd_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_we,
  input logic cmd_busy,
  input logic cmd_oe,
  input logic ev_rsp_end,
  input logic ev_timeout,
  input logic ev_illegal,
  input logic ev_idx_err
);

  p_busy_write_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_busy |=> ev_illegal);

  p_end_clears_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_end |-> !cmd_busy && $past(cmd_busy));

  p_timeout_clears_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> !cmd_busy && $past(cmd_busy));

  p_end_timeout_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rsp_end, ev_timeout}));

  p_end_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rsp_end |=> !ev_rsp_end);

  p_idx_err_with_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idx_err |-> ev_rsp_end);

  p_oe_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_busy);

endmodule

bind sd_cmd_frontend sd_cmd_frontend_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_we     (cmd_we),
  .cmd_busy   (cmd_busy),
  .cmd_oe     (cmd_oe),
  .ev_rsp_end (ev_rsp_end),
  .ev_timeout (ev_timeout),
  .ev_illegal (ev_illegal),
  .ev_idx_err (ev_idx_err)
);

// File: tb/sd_cmd_frontend_tb.sv
module sd_cmd_frontend_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] cw;
    logic [31:0] arg;
    logic [5:0]  ridx;
    logic [31:0] pay;
    logic        err;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'h1C11, 32'h0000_1234, 6'd17, 32'hA5A5_0001, 1'b0},
    '{16'h040D, 32'hDEAD_BEEF, 6'd13, 32'h1357_9BDF, 1'b0},
    '{16'h0437, 32'h0BAD_F00D, 6'd54, 32'h0F0F_F0F0, 1'b1},
    '{16'h0769, 32'h8000_0001, 6'd63, 32'hFFFF_0000, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         card_ce = 1'b1;
  logic         arg_we = 1'b0;
  logic [31:0]  arg_wdata = '0;
  logic         cmd_we = 1'b0;
  logic [15:0]  cmd_wdata = '0;
  logic         cmd_out, cmd_oe;
  logic         rsp_vld = 1'b0;
  logic         rsp_bit = 1'b1;
  logic         card_busy = 1'b0;
  logic         cmd_busy;
  logic [127:0] rsp_reg;
  logic         ev_rsp_end, ev_idx_err, ev_timeout, ev_illegal;

  int errors = 0;
  int checks = 0;
  bit fin = 1'b0;
  logic [127:0] exp_rsp = '0;
  logic [47:0]  fr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .card_ce(card_ce),
    .arg_we(arg_we), .arg_wdata(arg_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .rsp_vld(rsp_vld), .rsp_bit(rsp_bit), .card_busy(card_busy),
    .cmd_busy(cmd_busy), .rsp_reg(rsp_reg),
    .ev_rsp_end(ev_rsp_end), .ev_idx_err(ev_idx_err),
    .ev_timeout(ev_timeout), .ev_illegal(ev_illegal)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] cw, input logic [31:0] a, output logic [47:0] f);
    @(negedge clk); arg_we = 1'b1; arg_wdata = a;
    @(negedge clk); arg_we = 1'b0; cmd_we = 1'b1; cmd_wdata = cw;
    @(negedge clk); cmd_we = 1'b0; f[47] = cmd_out;
    for (int k = 1; k < 48; k++) begin
      @(negedge clk); f[47-k] = cmd_out;
    end
  endtask

  task automatic send_rsp(input int len, input logic [135:0] bits);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rsp_vld = 1'b1; rsp_bit = bits[len-1-i];
      @(negedge clk);
    end
    rsp_vld = 1'b0; rsp_bit = 1'b1;
  endtask

  task automatic wr_only(input logic [15:0] cw);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = cw;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [119:0] lpay;
    repeat (3) @(negedge clk);
    // reset state
    chk("R2 reset busy", 128'(cmd_busy), 128'd0);
    chk("R1 reset oe", 128'(cmd_oe), 128'd0);
    chk("R11 reset events", 128'({ev_rsp_end, ev_idx_err, ev_timeout, ev_illegal}), 128'd0);
    chk("R6 reset rsp", rsp_reg, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table of legal 48-bit commands
    for (int v = 0; v < 4; v++) begin
      issue(VECS[v].cw, VECS[v].arg, fr);
      chk("R1 frame", 128'(fr), 128'({2'b01, VECS[v].cw[5:0], VECS[v].arg, 7'd0, 1'b1}));
      chk("R2 busy during frame", 128'(cmd_busy), 128'd1);
      send_rsp(48, 136'({2'b00, VECS[v].ridx, VECS[v].pay, 7'd0, 1'b1}));
      exp_rsp = {exp_rsp[95:0], VECS[v].pay};
      chk("R8 end on last bit", 128'(ev_rsp_end), 128'd1);
      chk("R10 index check", 128'(ev_idx_err), 128'(VECS[v].err));
      chk("R6 shifted response", rsp_reg, exp_rsp);
      chk("R2 busy cleared", 128'(cmd_busy), 128'd0);
      @(negedge clk);
      chk("R11 single pulse", 128'({ev_rsp_end, ev_idx_err}), 128'd0);
    end

    // no-response command, with a write while busy
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 16'h0300;
    @(negedge clk); cmd_we = 1'b0;
    for (int k = 1; k < 48; k++) begin
      @(negedge clk);
      if (k == 10) begin cmd_we = 1'b1; cmd_wdata = 16'h0405; end
      if (k == 11) begin
        cmd_we = 1'b0;
        chk("R3 illegal while busy", 128'(ev_illegal), 128'd1);
        chk("R3 busy kept", 128'(cmd_busy), 128'd1);
      end
    end
    chk("R5 still busy on edge 47", 128'({cmd_busy, ev_rsp_end}), 128'b10);
    @(negedge clk);
    chk("R5 done on edge 48", 128'({cmd_busy, ev_rsp_end, cmd_oe}), 128'b010);
    @(negedge clk);
    chk("R3 rejected command not issued", 128'({cmd_busy, cmd_oe}), 128'd0);

    // field legality
    wr_only(16'h0B05);
    chk("R4 data with no response", 128'({ev_illegal, cmd_busy, cmd_oe}), 128'b100);
    wr_only(16'h0C0C);
    chk("R4 data on index 12", 128'({ev_illegal, cmd_busy, cmd_oe}), 128'b100);
    wr_only(16'h0111);
    chk("R4 reserved type", 128'({ev_illegal, cmd_busy, cmd_oe}), 128'b100);
    @(negedge clk);
    chk("R11 illegal pulse", 128'(ev_illegal), 128'd0);

    // timeout
    issue(16'h0408, 32'h0, fr);
    repeat (64) @(negedge clk);
    chk("R9 no timeout before 64", 128'({cmd_busy, ev_timeout}), 128'b10);
    @(negedge clk);
    chk("R9 timeout at 64", 128'({cmd_busy, ev_timeout, ev_rsp_end}), 128'b010);
    @(negedge clk);
    chk("R11 timeout pulse", 128'(ev_timeout), 128'd0);

    // 136-bit response
    lpay = {60'h0123_4567_89AB_CDE, 60'hFED_CBA9_8765_4321};
    issue(16'h0602, 32'h5555_AAAA, fr);
    send_rsp(136, {2'b00, 6'h3F, lpay, 7'd0, 1'b1});
    exp_rsp = {8'h00, lpay};
    chk("R7 long response", rsp_reg, exp_rsp);
    chk("R10 no index check on long", 128'({ev_rsp_end, ev_idx_err}), 128'b10);

    // busy response type with index mismatch
    card_busy = 1'b1;
    issue(16'h0507, 32'h0000_0007, fr);
    send_rsp(48, 136'({2'b00, 6'd6, 32'h2468_ACE0, 7'd0, 1'b1}));
    exp_rsp = {exp_rsp[95:0], 32'h2468_ACE0};
    chk("R8 held while card busy", 128'({cmd_busy, ev_rsp_end}), 128'b10);
    chk("R6 busy-type payload", rsp_reg, exp_rsp);
    repeat (3) @(negedge clk);
    chk("R8 still waiting", 128'({cmd_busy, ev_rsp_end}), 128'b10);
    card_busy = 1'b0;
    @(negedge clk);
    chk("R8 end after busy release", 128'({cmd_busy, ev_rsp_end}), 128'b01);
    chk("R10 mismatch on busy type", 128'(ev_idx_err), 128'd1);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule